// File: doc/BRIEF.md
# Power-Mode Clock Controller

This block decides, cycle by cycle, whether the processor core and the peripherals of a small microcontroller receive a clock, and which of three oscillators feeds them. It has seven operating modes: three run modes, three idle modes and sleep. Software writes a control word that holds an idle-enable bit and a two-bit source field. A strobe from the sleep instruction moves the device from run into idle or sleep. An interrupt or an ultra-low-power wake pulse brings it back to run.

Each oscillator is modelled only by a ready flag. A source change takes effect on the clock edge that accepts the write, provided the target oscillator is ready. If it is not ready, the controller keeps the old source and its enables, and flags the switch as pending until the target becomes ready. Every output comes from a register, so the enables only change on a clock edge.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (primary run), both clock enables are 1, src_sel_o is 0, switch_pend_o is 0, and the held idle bit and source field are 0.
- R2: The source field decodes as 00 to primary (src_sel_o = 0), 01 to secondary (src_sel_o = 1), and 10 or 11 to the internal oscillator (src_sel_o = 2). mode_o encodes run as {0, src}, idle as {1, src} and sleep as 7.
- R3: In every run mode, cpu_clk_en_o and per_clk_en_o are both 1.
- R4: In run, a sleep strobe with the held idle bit at 1 gives cpu_clk_en_o = 0, per_clk_en_o = 1 and mode_o = 4 + src from the next cycle.
- R5: In run, a sleep strobe with the held idle bit at 0 gives both enables at 0 and mode_o = 7 from the next cycle.
- R6: The idle bit that decides between idle and sleep is the value held before the strobe edge. A write in the same cycle as the strobe, or any later write, does not change the mode that was entered.
- R7: A write whose target source is ready updates src_sel_o on the same clock edge that accepts the write.
- R8: If the target source is not ready, src_sel_o and the enables keep their values and switch_pend_o is 1. The switch completes, and switch_pend_o clears, on the first edge at which the target's ready flag is 1.
- R9: In idle or sleep, irq_i or ulp_wake_i returns the device on the next cycle to the run mode of the active source, with both enables at 1.
- R10: Wake inputs have no effect in run. A sleep strobe has no effect in idle or sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_idle_i | input | 1 | Idle-enable bit to write |
| cfg_src_i | input | 2 | Source field to write |
| sleep_req_i | input | 1 | Sleep-instruction strobe |
| irq_i | input | 1 | Enabled interrupt pending |
| ulp_wake_i | input | 1 | Ultra-low-power wake pulse |
| src_rdy_i | input | 3 | Ready flags: bit 0 primary, bit 1 secondary, bit 2 internal |
| cpu_clk_en_o | output | 1 | Core clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| src_sel_o | output | 2 | Active source mux select |
| switch_pend_o | output | 1 | A source switch is waiting for its oscillator |
| mode_o | output | 3 | Current mode code |

## Verification
The source switch is swept over every value of the source field and all eight patterns of the ready flags. This separates switches that are taken at once from those held pending, and shows that the decode ignores the low bit of the internal code. Entry into idle and sleep is tried for every source, with each idle-bit value and each wake input, so the idle/sleep split and the return source are checked independently of each other. Directed sequences write the idle bit on the strobe cycle and while idle, and pulse wake inputs in run and repeated strobes while asleep. These show that the held bit is captured at the strobe and that the ignored events leave mode_o unchanged.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int SEL_W  = 2;
  localparam int MODE_W = 3;
  localparam int NSRC   = 3;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SLEEP = 2'd2
  } pm_state_e;

  localparam logic [SEL_W-1:0]  SRC_PRI    = 2'd0;
  localparam logic [SEL_W-1:0]  SRC_SEC    = 2'd1;
  localparam logic [SEL_W-1:0]  SRC_INT    = 2'd2;
  localparam logic [MODE_W-1:0] MODE_SLEEP = 3'd7;

  // 1x selects the internal block regardless of the low bit
  function automatic logic [SEL_W-1:0] src_decode(input logic [SEL_W-1:0] sel);
    if (sel[1])      return SRC_INT;
    else if (sel[0]) return SRC_SEC;
    else             return SRC_PRI;
  endfunction
endpackage

// File: rtl/pwr_cfg_reg.sv
module pwr_cfg_reg
  import pwr_mode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             idle_d_i,
  input  logic [SEL_W-1:0] sel_d_i,
  output logic             idle_q_o,
  output logic [SEL_W-1:0] tgt_n_o
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q_o <= 1'b0;
      sel_q    <= '0;
    end else if (we_i) begin
      idle_q_o <= idle_d_i;
      sel_q    <= sel_d_i;
    end
  end

  // target seen by the switch logic includes a write in flight
  assign tgt_n_o = src_decode(we_i ? sel_d_i : sel_q);
endmodule

// File: rtl/pwr_src_switch.sv
module pwr_src_switch
  import pwr_mode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] tgt_i,
  input  logic [NSRC-1:0]  rdy_i,
  output logic [SEL_W-1:0] act_n_o,
  output logic             pend_n_o
);
  logic [SEL_W-1:0] act_q;
  logic             tgt_rdy;

  always_comb begin
    tgt_rdy = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (tgt_i == SEL_W'(i)) tgt_rdy = rdy_i[i];
  end

  assign act_n_o  = (tgt_i != act_q && tgt_rdy) ? tgt_i : act_q;
  assign pend_n_o = (tgt_i != act_n_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= SRC_PRI;
    else         act_q <= act_n_o;
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sleep_req_i,
  input  logic      idle_q_i,
  input  logic      wake_i,
  output pm_state_e st_q_o,
  output pm_state_e st_n_o
);
  always_comb begin
    st_n_o = st_q_o;
    unique case (st_q_o)
      ST_RUN:   if (sleep_req_i) st_n_o = idle_q_i ? ST_IDLE : ST_SLEEP;
      ST_IDLE,
      ST_SLEEP: if (wake_i) st_n_o = ST_RUN;
      default:  st_n_o = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q_o <= ST_RUN;
    else         st_q_o <= st_n_o;
  end
endmodule

// File: rtl/pwr_clk_out.sv
module pwr_clk_out
  import pwr_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pm_state_e         st_n_i,
  input  logic [SEL_W-1:0]  act_n_i,
  input  logic              pend_n_i,
  output logic              cpu_en_o,
  output logic              per_en_o,
  output logic [SEL_W-1:0]  src_sel_o,
  output logic              pend_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [MODE_W-1:0] mode_n;

  always_comb begin
    if (st_n_i == ST_SLEEP) mode_n = MODE_SLEEP;
    else                    mode_n = {st_n_i == ST_IDLE, act_n_i};
  end

  // all enables leave a flop: no combinational edge reaches the gates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_en_o  <= 1'b1;
      per_en_o  <= 1'b1;
      src_sel_o <= SRC_PRI;
      pend_o    <= 1'b0;
      mode_o    <= '0;
    end else begin
      cpu_en_o  <= (st_n_i == ST_RUN);
      per_en_o  <= (st_n_i != ST_SLEEP);
      src_sel_o <= act_n_i;
      pend_o    <= pend_n_i;
      mode_o    <= mode_n;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_idle_i,
  input  logic [SEL_W-1:0]  cfg_src_i,
  input  logic              sleep_req_i,
  input  logic              irq_i,
  input  logic              ulp_wake_i,
  input  logic [NSRC-1:0]   src_rdy_i,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic [SEL_W-1:0]  src_sel_o,
  output logic              switch_pend_o,
  output logic [MODE_W-1:0] mode_o
);
  logic             idle_q;
  logic [SEL_W-1:0] tgt_n;
  logic [SEL_W-1:0] act_n;
  logic             pend_n;
  pm_state_e        st_q;
  pm_state_e        st_n;

  pwr_cfg_reg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .idle_d_i (cfg_idle_i),
    .sel_d_i  (cfg_src_i),
    .idle_q_o (idle_q),
    .tgt_n_o  (tgt_n)
  );

  pwr_src_switch u_sw (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tgt_i    (tgt_n),
    .rdy_i    (src_rdy_i),
    .act_n_o  (act_n),
    .pend_n_o (pend_n)
  );

  pwr_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .idle_q_i    (idle_q),
    .wake_i      (irq_i | ulp_wake_i),
    .st_q_o      (st_q),
    .st_n_o      (st_n)
  );

  pwr_clk_out u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .st_n_i    (st_n),
    .act_n_i   (act_n),
    .pend_n_i  (pend_n),
    .cpu_en_o  (cpu_clk_en_o),
    .per_en_o  (per_clk_en_o),
    .src_sel_o (src_sel_o),
    .pend_o    (switch_pend_o),
    .mode_o    (mode_o)
  );

  AST_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_sel_o != 2'b11); // R2
  AST_RUN_CLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !sleep_req_i) |=> (cpu_clk_en_o && per_clk_en_o && !mode_o[2])); // R3
  AST_IDLE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && sleep_req_i && idle_q) |=> (!cpu_clk_en_o && per_clk_en_o && mode_o[2] && mode_o != MODE_SLEEP)); // R4
  AST_SLEEP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && sleep_req_i && !idle_q) |=> (!cpu_clk_en_o && !per_clk_en_o && mode_o == MODE_SLEEP)); // R5
  AST_SWITCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (switch_pend_o && !cfg_we_i && src_rdy_i == '0) |=> ($stable(src_sel_o) && switch_pend_o)); // R8
  AST_WAKE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_RUN && (irq_i || ulp_wake_i)) |=> (cpu_clk_en_o && per_clk_en_o && !mode_o[2])); // R9
  AST_LOWPWR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLEEP && !irq_i && !ulp_wake_i) |=> (mode_o == MODE_SLEEP && !per_clk_en_o)); // R10
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic       cfg_idle_i = 1'b0;
  logic [1:0] cfg_src_i = 2'd0;
  logic       sleep_req_i = 1'b0;
  logic       irq_i = 1'b0;
  logic       ulp_wake_i = 1'b0;
  logic [2:0] src_rdy_i = 3'b111;
  logic       cpu_clk_en_o, per_clk_en_o, switch_pend_o;
  logic [1:0] src_sel_o;
  logic [2:0] mode_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pwr_mode_ctrl uut (.*);

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic clear_in();
    cfg_we_i = 1'b0; sleep_req_i = 1'b0; irq_i = 1'b0; ulp_wake_i = 1'b0;
  endtask

  function automatic int dec(input int s);
    return (s >= 2) ? 2 : s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    chk("R1 mode", mode_o, 0);
    chk("R1 cpu_en", cpu_clk_en_o, 1);
    chk("R1 per_en", per_clk_en_o, 1);
    chk("R1 src_sel", src_sel_o, 0);
    chk("R1 pend", switch_pend_o, 0);
    rst_ni = 1'b1;
    cyc();
    // held idle bit 0 after reset: strobe must enter sleep (R1)
    sleep_req_i = 1'b1; cyc(); clear_in();
    chk("R1 idle bit reset value", mode_o, 7);
    irq_i = 1'b1; cyc(); clear_in();
    chk("R9 wake from sleep", mode_o, 0);

    // source switch sweep: R2 R7 R8
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 8; r++) begin
        int t;
        bit rdy;
        t = dec(s);
        src_rdy_i = 3'b111; cfg_we_i = 1'b1; cfg_idle_i = 1'b0; cfg_src_i = 2'd0;
        cyc(); clear_in();
        src_rdy_i = 3'(r); cfg_we_i = 1'b1; cfg_src_i = 2'(s);
        cyc(); clear_in();
        rdy = r[t];
        if (t == 0 || rdy) begin
          chk("R7 src_sel at write", src_sel_o, t);
          chk("R7 no pend", switch_pend_o, 0);
        end else begin
          chk("R8 src_sel held", src_sel_o, 0);
          chk("R8 pend set", switch_pend_o, 1);
          chk("R8 run enables held", cpu_clk_en_o & per_clk_en_o, 1);
          cyc();
          chk("R8 still pending", switch_pend_o, 1);
        end
        src_rdy_i = 3'b111; cyc();
        chk("R8 switch done", src_sel_o, t);
        chk("R8 pend cleared", switch_pend_o, 0);
        chk("R2 run mode code", mode_o, t);
      end
    end

    // mode entry sweep: R3 R4 R5 R9
    src_rdy_i = 3'b111;
    for (int s = 0; s < 4; s++) begin
      for (int idl = 0; idl < 2; idl++) begin
        for (int wk = 0; wk < 2; wk++) begin
          int t;
          t = dec(s);
          cfg_we_i = 1'b1; cfg_idle_i = 1'(idl); cfg_src_i = 2'(s);
          cyc(); clear_in();
          chk("R3 run cpu_en", cpu_clk_en_o, 1);
          chk("R3 run per_en", per_clk_en_o, 1);
          sleep_req_i = 1'b1; cyc(); clear_in();
          if (idl == 1) begin
            chk("R4 idle mode", mode_o, 4 + t);
            chk("R4 idle cpu_en", cpu_clk_en_o, 0);
            chk("R4 idle per_en", per_clk_en_o, 1);
          end else begin
            chk("R5 sleep mode", mode_o, 7);
            chk("R5 sleep cpu_en", cpu_clk_en_o, 0);
            chk("R5 sleep per_en", per_clk_en_o, 0);
          end
          cyc();
          chk("R10 low-power held", mode_o, idl == 1 ? 4 + t : 7);
          if (wk == 0) irq_i = 1'b1; else ulp_wake_i = 1'b1;
          cyc(); clear_in();
          chk("R9 wake mode", mode_o, t);
          chk("R9 wake enables", cpu_clk_en_o & per_clk_en_o, 1);
        end
      end
    end

    // R6: idle bit captured at the strobe
    cfg_we_i = 1'b1; cfg_idle_i = 1'b1; cfg_src_i = 2'd1; cyc(); clear_in();
    sleep_req_i = 1'b1; cfg_we_i = 1'b1; cfg_idle_i = 1'b0; cfg_src_i = 2'd1;
    cyc(); clear_in();
    chk("R6 same-cycle write ignored (idle)", mode_o, 5);
    cfg_we_i = 1'b1; cfg_idle_i = 1'b0; cfg_src_i = 2'd1; cyc(); clear_in();
    chk("R6 later write keeps idle", mode_o, 5);
    chk("R6 later write keeps cpu off", cpu_clk_en_o, 0);
    irq_i = 1'b1; cyc(); clear_in();
    chk("R9 wake to secondary run", mode_o, 1);
    sleep_req_i = 1'b1; cfg_we_i = 1'b1; cfg_idle_i = 1'b1; cfg_src_i = 2'd1;
    cyc(); clear_in();
    chk("R6 same-cycle write ignored (sleep)", mode_o, 7);
    ulp_wake_i = 1'b1; cyc(); clear_in();
    chk("R9 ulp wake", mode_o, 1);

    // R10: wake in run ignored, strobe in idle/sleep ignored
    irq_i = 1'b1; ulp_wake_i = 1'b1; cyc(); clear_in();
    chk("R10 wake in run", mode_o, 1);
    chk("R10 wake in run enables", cpu_clk_en_o & per_clk_en_o, 1);
    sleep_req_i = 1'b1; cyc(); clear_in();
    chk("R4 idle entry secondary", mode_o, 5);
    cfg_we_i = 1'b1; cfg_idle_i = 1'b0; cfg_src_i = 2'd1; cyc(); clear_in();
    sleep_req_i = 1'b1; cyc(); clear_in();
    chk("R10 strobe in idle", mode_o, 5);
    irq_i = 1'b1; cyc(); clear_in();
    sleep_req_i = 1'b1; cyc(); clear_in();
    chk("R5 sleep entry", mode_o, 7);
    sleep_req_i = 1'b1; cyc(); clear_in();
    chk("R10 strobe in sleep", mode_o, 7);
    chk("R10 strobe in sleep per_en", per_clk_en_o, 0);
    irq_i = 1'b1; cyc(); clear_in();
    chk("R9 final wake", mode_o, 1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule